// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block sits beside a floating-point datapath and turns the exception flags of each completed operation into architectural state. Every operation presents its own pending-flag vector together with an ignore mask, the number of its destination register and a mode bit that selects whether software completion is in force. The unit merges the flags into a sticky status register and decides, for that operation alone, whether an arithmetic trap is taken. A trap produces a one-cycle strobe, a summary word naming the flags involved, and a 64-bit destination mask with one bit set.

The two raise policies differ. Without software completion every flag that survives the ignore mask traps, and the trap enables are not looked at; the sticky status takes every pending flag, ignored or not. With software completion the ignore mask is applied before the sticky update, the summary carries only the surviving flags that are also enabled, and a completion tag bit is set in the summary.

The unit also holds the per-flag trap enable vector, a two-bit rounding-mode control and a flush-to-zero control, each written through its own setter strobe.

Top module: `fp_exc_trap_unit`

## Requirements
- R1: Flag bit positions are shared by the pending vector, ignore mask, enable vector, sticky status and summary: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow; summary bit 6 is the software-completion tag.
- R2: An operation whose pending vector is zero, or a cycle with no operation strobe, changes no status and raises no trap.
- R3: Without software completion, the sticky status takes the OR of all pending flags, including ignored ones.
- R4: Without software completion, a trap is raised when any pending flag is outside the ignore mask; the summary holds exactly those flags with bit 6 clear, whatever the enable vector holds.
- R5: With software completion, only pending flags outside the ignore mask are ORed into the sticky status.
- R6: With software completion, a trap is raised when any pending flag is outside the ignore mask; the summary holds those flags ANDed with the enable vector, with bit 6 set.
- R7: On a trap the destination mask has exactly the bit at the destination register number set; summary and mask hold their values until the next trap.
- R8: Status, trap strobe, summary and mask change on the clock edge that samples the operation strobe; the trap strobe is high for one cycle per trapping operation.
- R9: A trap summary carries only the flags of its own operation, never those of earlier operations.
- R10: The rounding mode (0 nearest-even, 1 toward zero, 2 up, 3 down), flush-to-zero and enable vector are each loaded by their own write strobe on the next edge and otherwise hold; the enable vector used by an operation is the value held before that edge.
- R11: Reset clears the sticky status, enables, flush-to-zero, trap strobe, summary and mask, and sets the rounding mode to 0 (nearest-even).
- R12: A setter write and an operation in the same cycle both take effect; the setter alters only its own control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation completes this cycle |
| pend_i | input | 6 | Pending flags of the operation |
| ignore_i | input | 6 | Flags excluded from trapping |
| dest_i | input | 6 | Destination register number |
| swc_i | input | 1 | Software-completion mode |
| rm_wr_i | input | 1 | Rounding-mode write strobe |
| rm_i | input | 2 | Rounding mode to write |
| ftz_wr_i | input | 1 | Flush-to-zero write strobe |
| ftz_i | input | 1 | Flush-to-zero value to write |
| en_wr_i | input | 1 | Enable-vector write strobe |
| en_i | input | 6 | Enable vector to write |
| status_o | output | 6 | Sticky status |
| enable_o | output | 6 | Current trap enables |
| rm_o | output | 2 | Current rounding mode |
| ftz_o | output | 1 | Current flush-to-zero control |
| trap_o | output | 1 | Trap strobe |
| trap_sum_o | output | 7 | Trap summary word |
| trap_dest_o | output | 64 | One-hot destination mask |

## Verification
Every result of this block is due one edge after its stimulus: an operation or setter presented before edge N shows on status, enables, controls, trap strobe, summary and mask right after edge N, and the strobe is gone after edge N+1. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge and compares all outputs 1 ns after that edge, so each comparison lands on the cycle the result is due. Directed checks read outputs on the following falling edge, when the trap strobe of the operation just sampled is still high.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int SUM_W     = NUM_FLAGS + 1;
  localparam int SWC_BIT   = NUM_FLAGS;
  localparam int RM_W      = 2;

  localparam int FL_INV = 0;
  localparam int FL_DZE = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INE = 4;
  localparam int FL_IOV = 5;

  typedef logic [NUM_FLAGS-1:0] flags_t;
  typedef logic [SUM_W-1:0]     summary_t;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;
endpackage

// File: rtl/fpx_flag_filter.sv
module fpx_flag_filter
  import fpx_pkg::*;
(
  input  flags_t   pend_i,
  input  flags_t   ignore_i,
  input  flags_t   enable_i,
  input  logic     swc_i,
  output flags_t   sticky_add_o,
  output summary_t sum_o,
  output logic     trap_req_o
);
  flags_t surv;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign surv[i]         = pend_i[i] & ~ignore_i[i];
    // completion mode masks before sticky; plain mode records everything
    assign sticky_add_o[i] = swc_i ? surv[i] : pend_i[i];
    assign sum_o[i]        = surv[i] & (~swc_i | enable_i[i]);
  end

  assign sum_o[SWC_BIT] = swc_i;
  assign trap_req_o     = |surv;
endmodule

// File: rtl/fpx_ctl_regs.sv
module fpx_ctl_regs
  import fpx_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           upd_i,
  input  flags_t         sticky_add_i,
  input  logic           rm_wr_i,
  input  logic [RM_W-1:0] rm_i,
  input  logic           ftz_wr_i,
  input  logic           ftz_i,
  input  logic           en_wr_i,
  input  flags_t         en_i,
  output flags_t         status_o,
  output flags_t         enable_o,
  output logic [RM_W-1:0] rm_o,
  output logic           ftz_o
);
  flags_t status_q, enable_q;
  rmode_e rm_q;
  logic   ftz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (upd_i) begin
      status_q <= status_q | sticky_add_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      rm_q     <= RM_NEAR_EVEN;
      ftz_q    <= 1'b0;
    end else begin
      if (en_wr_i)  enable_q <= en_i;
      if (rm_wr_i)  rm_q     <= rmode_e'(rm_i);
      if (ftz_wr_i) ftz_q    <= ftz_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign rm_o     = rm_q;
  assign ftz_o    = ftz_q;
endmodule

// File: rtl/fpx_trap_report.sv
module fpx_trap_report
  import fpx_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  summary_t            sum_i,
  input  logic [REG_W-1:0]    dest_i,
  output logic                trap_o,
  output summary_t            sum_o,
  output logic [NUM_REGS-1:0] dest_o
);
  logic [NUM_REGS-1:0] dest_dec;
  logic [NUM_REGS-1:0] dest_q;
  summary_t            sum_q;
  logic                trap_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign dest_dec[r] = (dest_i == REG_W'(r));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      sum_q  <= '0;
      dest_q <= '0;
    end else begin
      trap_q <= fire_i;
      if (fire_i) begin
        sum_q  <= sum_i;
        dest_q <= dest_dec;
      end
    end
  end

  assign trap_o = trap_q;
  assign sum_o  = sum_q;
  assign dest_o = dest_q;
endmodule

// File: rtl/fp_exc_trap_unit.sv
module fp_exc_trap_unit
  import fpx_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [NUM_FLAGS-1:0] pend_i,
  input  logic [NUM_FLAGS-1:0] ignore_i,
  input  logic [REG_W-1:0]    dest_i,
  input  logic                swc_i,
  input  logic                rm_wr_i,
  input  logic [RM_W-1:0]     rm_i,
  input  logic                ftz_wr_i,
  input  logic                ftz_i,
  input  logic                en_wr_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic [NUM_FLAGS-1:0] enable_o,
  output logic [RM_W-1:0]     rm_o,
  output logic                ftz_o,
  output logic                trap_o,
  output logic [SUM_W-1:0]    trap_sum_o,
  output logic [NUM_REGS-1:0] trap_dest_o
);
  flags_t   sticky_add, enable_cur;
  summary_t sum_next;
  logic     trap_req;
  logic     op_live;

  // a zero pending vector is a no-op
  assign op_live = op_valid_i & (|pend_i);

  fpx_flag_filter u_filter (
    .pend_i       (pend_i),
    .ignore_i     (ignore_i),
    .enable_i     (enable_cur),
    .swc_i        (swc_i),
    .sticky_add_o (sticky_add),
    .sum_o        (sum_next),
    .trap_req_o   (trap_req)
  );

  fpx_ctl_regs u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (op_live),
    .sticky_add_i (sticky_add),
    .rm_wr_i      (rm_wr_i),
    .rm_i         (rm_i),
    .ftz_wr_i     (ftz_wr_i),
    .ftz_i        (ftz_i),
    .en_wr_i      (en_wr_i),
    .en_i         (en_i),
    .status_o     (status_o),
    .enable_o     (enable_cur),
    .rm_o         (rm_o),
    .ftz_o        (ftz_o)
  );

  fpx_trap_report #(.NUM_REGS(NUM_REGS)) u_report (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (op_live & trap_req),
    .sum_i  (sum_next),
    .dest_i (dest_i),
    .trap_o (trap_o),
    .sum_o  (trap_sum_o),
    .dest_o (trap_dest_o)
  );

  assign enable_o = enable_cur;
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker
  import fpx_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 op_valid_i,
  input logic [NUM_FLAGS-1:0] pend_i,
  input logic                 swc_i,
  input logic                 rm_wr_i,
  input logic [REG_W-1:0]     dest_i,
  input logic [NUM_FLAGS-1:0] status_o,
  input logic [RM_W-1:0]      rm_o,
  input logic                 trap_o,
  input logic [SUM_W-1:0]     trap_sum_o,
  input logic [NUM_REGS-1:0]  trap_dest_o
);
  AST_TRAP_NEEDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_valid_i) && ($past(pend_i) != '0)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(op_valid_i) |-> $stable(status_o) && !trap_o); // R2

  AST_ZERO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_valid_i) && $past(pend_i) == '0) |-> $stable(status_o) && !trap_o); // R2

  AST_STICKY_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~status_o) == '0)); // R3

  AST_DEST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $countones(trap_dest_o) == 1 && trap_dest_o[$past(dest_i)]); // R7

  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> $stable(trap_sum_o) && $stable(trap_dest_o)); // R7

  AST_SWC_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_sum_o[SWC_BIT] == $past(swc_i)); // R6

  AST_RM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rm_wr_i) |-> $stable(rm_o)); // R10
endmodule

bind fp_exc_trap_unit fpx_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .pend_i      (pend_i),
  .swc_i       (swc_i),
  .rm_wr_i     (rm_wr_i),
  .dest_i      (dest_i),
  .status_o    (status_o),
  .rm_o        (rm_o),
  .trap_o      (trap_o),
  .trap_sum_o  (trap_sum_o),
  .trap_dest_o (trap_dest_o)
);

// File: tb/fp_exc_trap_unit_test.sv
`timescale 1ns/1ps
module fp_exc_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_v = 1'b0;
  logic [5:0]  pend = '0, ign = '0, dest = '0, en = '0;
  logic        swc = 1'b0, rm_w = 1'b0, ftz_w = 1'b0, ftz = 1'b0, en_w = 1'b0;
  logic [1:0]  rm = '0;

  logic [5:0]  status_o, enable_o;
  logic [1:0]  rm_o;
  logic        ftz_o, trap_o;
  logic [6:0]  sum_o;
  logic [63:0] dest_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [5:0]  m_status, m_en;
  logic [1:0]  m_rm;
  logic        m_ftz, m_trap;
  logic [6:0]  m_sum;
  logic [63:0] m_dest;

  always #2 clk = ~clk;

  fp_exc_trap_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_v), .pend_i(pend), .ignore_i(ign),
    .dest_i(dest), .swc_i(swc), .rm_wr_i(rm_w), .rm_i(rm), .ftz_wr_i(ftz_w),
    .ftz_i(ftz), .en_wr_i(en_w), .en_i(en), .status_o(status_o), .enable_o(enable_o),
    .rm_o(rm_o), .ftz_o(ftz_o), .trap_o(trap_o), .trap_sum_o(sum_o), .trap_dest_o(dest_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = '0; m_en = '0; m_rm = 2'd0; m_ftz = 1'b0;
      m_trap = 1'b0; m_sum = '0; m_dest = '0;
    end else begin
      logic [5:0] surv;
      surv = pend & ~ign;
      m_trap = 1'b0;
      if (op_v && pend != 0) begin
        if (swc) m_status = m_status | surv;
        else     m_status = m_status | pend;
        if (surv != 0) begin
          m_trap = 1'b1;
          m_sum  = swc ? {1'b1, surv & m_en} : {1'b0, surv};
          m_dest = 64'd1 << dest;
        end
      end
      if (en_w)  m_en  = en;
      if (rm_w)  m_rm  = rm;
      if (ftz_w) m_ftz = ftz;
      #1;
      chk("R3/R5 status model", 64'(status_o), 64'(m_status));
      chk("R8 trap model", 64'(trap_o), 64'(m_trap));
      chk("R4/R6 summary model", 64'(sum_o), 64'(m_sum));
      chk("R7 dest model", dest_o, m_dest);
      chk("R10 enable model", 64'(enable_o), 64'(m_en));
      chk("R10 rm model", 64'(rm_o), 64'(m_rm));
      chk("R10 ftz model", 64'(ftz_o), 64'(m_ftz));
    end
  end

  // one cycle of stimulus, then idle; returns on the falling edge after the sampling edge
  task automatic cyc(input logic v, input logic [5:0] p, input logic [5:0] ig, input logic [5:0] d,
                     input logic s, input logic rw, input logic [1:0] r, input logic fw,
                     input logic f, input logic ew, input logic [5:0] e);
    @(negedge clk);
    op_v = v; pend = p; ign = ig; dest = d; swc = s;
    rm_w = rw; rm = r; ftz_w = fw; ftz = f; en_w = ew; en = e;
    @(negedge clk);
    op_v = 0; pend = 0; ign = 0; swc = 0; rm_w = 0; ftz_w = 0; en_w = 0;
  endtask

  task automatic op(input logic [5:0] p, input logic [5:0] ig, input logic [5:0] d, input logic s);
    cyc(1'b1, p, ig, d, s, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset status", 64'(status_o), 0);
    chk("R11 reset rm nearest-even", 64'(rm_o), 0);
    chk("R11 reset trap/sum/dest", {trap_o, sum_o, dest_o[55:0]}, 0);
    rst_n = 1'b1;

    op(6'h08, 6'h08, 6'd3, 1'b0);
    chk("R3 ignored flag still sticky", 64'(status_o), 64'h08);
    chk("R3 fully ignored no trap", 64'(trap_o), 0);

    op(6'h14, 6'h10, 6'd5, 1'b0);
    chk("R4 trap raised", 64'(trap_o), 1);
    chk("R4 summary unignored only", 64'(sum_o), 64'h04);
    chk("R4 status", 64'(status_o), 64'h1C);
    chk("R7 dest bit 5", dest_o, 64'h20);

    @(negedge clk);
    chk("R8 strobe one cycle", 64'(trap_o), 0);
    chk("R7 summary held", 64'(sum_o), 64'h04);

    op(6'h00, 6'h00, 6'd9, 1'b0);
    chk("R2 zero pending no trap", 64'(trap_o), 0);
    chk("R2 zero pending no status change", 64'(status_o), 64'h1C);

    op(6'h20, 6'h20, 6'd1, 1'b1);
    chk("R5 ignored flag not sticky", 64'(status_o), 64'h1C);

    cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 6'h03);
    chk("R10 enable written", 64'(enable_o), 64'h03);

    op(6'h06, 6'h00, 6'd63, 1'b1);
    chk("R6 completion trap", 64'(trap_o), 1);
    chk("R6 summary enabled plus tag", 64'(sum_o), 64'h42);
    chk("R5 status", 64'(status_o), 64'h1E);
    chk("R7 dest bit 63", dest_o, 64'h8000_0000_0000_0000);

    op(6'h10, 6'h00, 6'd2, 1'b1);
    chk("R6 trap with no enabled flag", 64'(trap_o), 1);
    chk("R6 summary tag only", 64'(sum_o), 64'h40);

    op(6'h01, 6'h00, 6'd0, 1'b0);
    chk("R9 summary own flags only", 64'(sum_o), 64'h01);
    chk("R4 enables not consulted", 64'(trap_o), 1);

    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 6'h00);
    chk("R10 rm written", 64'(rm_o), 3);
    chk("R10 ftz written", 64'(ftz_o), 1);

    cyc(1'b1, 6'h22, 6'h00, 6'd7, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 6'h00);
    chk("R12 rm applied with op", 64'(rm_o), 1);
    chk("R12 op applied with setter", 64'(sum_o), 64'h22);
    chk("R12 setter leaves ftz", 64'(ftz_o), 1);
    chk("R12 setter leaves enables", 64'(enable_o), 64'h03);

    for (int i = 0; i < 6; i++) begin
      op(6'(1 << i), 6'h00, 6'(i), 1'b0);
      chk("R1 flag position in summary", 64'(sum_o), 64'(1 << i));
    end
    chk("R1 all flags sticky", 64'(status_o), 64'h3F);

    // back-to-back operations
    @(negedge clk);
    op_v = 1; pend = 6'h02; ign = 0; dest = 6'd10; swc = 0;
    @(negedge clk);
    pend = 6'h04; dest = 6'd11;
    @(negedge clk);
    chk("R8 second of pair traps", 64'(trap_o), 1);
    chk("R9 second of pair summary", 64'(sum_o), 64'h04);
    op_v = 0; pend = 0;
    @(negedge clk);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset rm", 64'(rm_o), 0);
    chk("R11 reset enables/ftz/status", {enable_o, ftz_o, status_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule